// File: doc/BRIEF.md
# Redundant PCM Line Comparator

This block supports redundant PCM transmission paths. It watches four serial PCM input lines as two fixed pairs, line 0 with line 1 and line 2 with line 3. For each 8-bit time slot of the frame, it checks whether the two lines of a pair carried exactly the same bits. The bit clock is the block's clock, and every line is sampled on its rising edge. A frame sync pulse marks bit 0 of slot 0. A slot and bit counter advances on every edge and wraps at the end of the frame even when no sync arrives.

When the two lines of an enabled pair differ in any bit of a slot, the block takes the decision as that slot's last bit is sampled. It then raises a level interrupt. It also records, in an 8-bit capture register, which pair differed and the slot number. The first capture is held until the host reads it. A read clears the capture and drops the interrupt, unless a new mismatch arrives on that same edge. The check does not depend on how the surrounding PCM interface is configured.

Top module: `pcm_pair_compare`

## Requirements
- R1: After reset, `irq` is 0 and `cap_q` is 8'h00. A reset also discards any pending capture.
- R2: When both lines of every enabled pair carry identical bits, `irq` stays 0.
- R3: A difference in any one or more bits of a slot on an enabled pair sets `irq` to 1. It also loads `cap_q[6:0]` with that slot's number, counted from the last frame sync.
- R4: `cap_q[7]` identifies the pair: 0 for lines 0/1 and 1 for lines 2/3.
- R5: While `irq` is 1 and no read occurs, `cap_q` keeps the first capture. Later mismatches leave both `cap_q` and `irq` unchanged.
- R6: A cycle with `rd_en` high and no new mismatch clears `cap_q` to 8'h00 and `irq` to 0 on that edge.
- R7: If a read and a new mismatch decision fall on the same edge, the new mismatch is captured and `irq` stays 1.
- R8: A pair whose bit in `pair_en` is 0 never raises a mismatch (`pair_en[0]` controls lines 0/1 and `pair_en[1]` controls lines 2/3). The other pair keeps working.
- R9: A sample taken with `fsync` high is bit 0 of slot 0, whatever the counter held before.
- R10: If both pairs mismatch in the same slot, pair 0 is reported (`cap_q[7]` = 0).
- R11: Without `fsync`, the counter wraps from the last bit of slot SLOTS-1 to bit 0 of slot 0.
- R12: The mismatch decision is taken on the edge that samples bit 7 of the slot. `irq` is high right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock; lines are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync; high on the sample that is bit 0 of slot 0 |
| rxd | input | 4 | Serial PCM input lines 0 to 3 |
| pair_en | input | 2 | Per-pair comparison enable |
| rd_en | input | 1 | Host read strobe that clears the capture |
| irq | output | 1 | Level mismatch interrupt request |
| cap_q | output | 8 | Capture: bit 7 is the pair, bits 6:0 are the slot number |

## Verification
On every cycle, the assertions check the following:
- the counter restarts on a sync pulse and wraps at the end of the frame;
- a mismatch decision always leaves the interrupt set;
- the capture stays frozen while no read occurs;
- a plain read clears the capture and the interrupt;
- the captured slot number stays inside the frame.

Other behaviour can only be shown by the bench's scenarios: that the slot number matches the stimulus, that pair priority and pair enables act correctly, and the exact edge at which the interrupt rises.

// File: rtl/pcmcmp_pkg.sv
package pcmcmp_pkg;

    localparam int BITS_PER_SLOT = 8;
    localparam int BIT_IDX_W     = 3;
    localparam int SLOT_FIELD_W  = 7;
    localparam int NUM_PAIRS     = 2;

    // Sample position inside the frame for the bit taken on the current edge
    typedef struct packed {
        logic                    first;
        logic                    last;
        logic [SLOT_FIELD_W-1:0] slot;
    } pos_t;

    // Capture word as seen by the host
    typedef struct packed {
        logic                    pair;
        logic [SLOT_FIELD_W-1:0] slot;
    } cap_t;

    function automatic cap_t make_cap(input logic pair, input logic [SLOT_FIELD_W-1:0] slot);
        cap_t c;
        c.pair = pair;
        c.slot = slot;
        return c;
    endfunction

endpackage

// File: rtl/pcmcmp_slot_ctr.sv
module pcmcmp_slot_ctr
    import pcmcmp_pkg::*;
#(
    parameter int SLOTS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic fsync,
    output pos_t pos
);
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    logic [BIT_IDX_W-1:0] bit_q;
    logic [SW-1:0]        slot_q;
    logic [BIT_IDX_W-1:0] cur_bit;
    logic [SW-1:0]        cur_slot;

    // A sync pulse overrides the counter for the sample taken on this edge
    always_comb begin
        cur_bit    = fsync ? '0 : bit_q;
        cur_slot   = fsync ? '0 : slot_q;
        pos.first  = (cur_bit == '0);
        pos.last   = (cur_bit == BIT_IDX_W'(BITS_PER_SLOT - 1));
        pos.slot   = SLOT_FIELD_W'(cur_slot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (pos.last) begin
            bit_q  <= '0;
            slot_q <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
        end else begin
            bit_q  <= cur_bit + 1'b1;
            slot_q <= cur_slot;
        end
    end

    p_sync_restart_r9: assert property (@(posedge clk) disable iff (rst)
        fsync |=> (bit_q == BIT_IDX_W'(1)) && (slot_q == '0 || BITS_PER_SLOT == 1));

    p_frame_wrap_r11: assert property (@(posedge clk) disable iff (rst)
        (!fsync && bit_q == BIT_IDX_W'(BITS_PER_SLOT - 1) && slot_q == LAST_SLOT)
        |=> (slot_q == '0 && bit_q == '0));

endmodule

// File: rtl/pcmcmp_pair_lane.sv
module pcmcmp_pair_lane
    import pcmcmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic line_a,
    input  logic line_b,
    input  pos_t pos,
    output logic slot_err
);
    logic acc_q;
    logic seen;

    // Running OR of bit differences; restarts at bit 0 of every slot
    always_comb begin
        seen     = (pos.first ? 1'b0 : acc_q) | (en & (line_a ^ line_b));
        slot_err = pos.last & seen;
    end

    always_ff @(posedge clk) begin
        if (rst)           acc_q <= 1'b0;
        else if (pos.last) acc_q <= 1'b0;
        else               acc_q <= seen;
    end

endmodule

// File: rtl/pcmcmp_capture.sv
module pcmcmp_capture
    import pcmcmp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PAIRS-1:0]    slot_err,
    input  logic [SLOT_FIELD_W-1:0] slot,
    input  logic                    rd_en,
    output logic                    irq,
    output cap_t                    cap
);
    logic mis_evt;
    logic pick;

    assign mis_evt = |slot_err;
    assign pick    = ~slot_err[0];   // pair 0 wins when both differ

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            cap <= '0;
        end else if (mis_evt && (!irq || rd_en)) begin
            irq <= 1'b1;
            cap <= make_cap(pick, slot);
        end else if (irq && rd_en) begin
            irq <= 1'b0;
            cap <= '0;
        end
    end

    p_raise_r3: assert property (@(posedge clk) disable iff (rst)
        mis_evt |=> irq);

    p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (irq && !rd_en) |=> ($stable(cap) && irq));

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (irq && rd_en && !mis_evt) |=> (!irq && cap == '0));

    p_read_race_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && rd_en && mis_evt) |=> (irq && cap.slot == $past(slot)));

endmodule

// File: rtl/pcm_pair_compare.sv
module pcm_pair_compare
    import pcmcmp_pkg::*;
#(
    parameter int SLOTS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fsync,
    input  logic [3:0] rxd,
    input  logic [1:0] pair_en,
    input  logic       rd_en,
    output logic       irq,
    output logic [7:0] cap_q
);
    pos_t                 pos;
    logic [NUM_PAIRS-1:0] slot_err;
    cap_t                 cap;

    pcmcmp_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .fsync (fsync),
        .pos   (pos)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_lane
        pcmcmp_pair_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .en       (pair_en[g]),
            .line_a   (rxd[2*g]),
            .line_b   (rxd[2*g+1]),
            .pos      (pos),
            .slot_err (slot_err[g])
        );
    end

    pcmcmp_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .slot_err (slot_err),
        .slot     (pos.slot),
        .rd_en    (rd_en),
        .irq      (irq),
        .cap      (cap)
    );

    assign cap_q = cap;

    p_slot_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (int'(cap_q[6:0]) < SLOTS));

endmodule

// File: tb/pcm_pair_compare_bench.sv
`timescale 1ns/1ps
module pcm_pair_compare_bench;
    localparam int SLOTS = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic [1:0] pair_en = 2'b11;
    logic       rd_en = 1'b0;
    logic       irq;
    logic [7:0] cap_q;

    int checks = 0;
    int fails = 0;
    int rise_at;
    bit seen;

    always #2.5 clk = ~clk;

    pcm_pair_compare #(.SLOTS(SLOTS)) u_pcm_pair_compare (
        .clk(clk), .rst(rst), .fsync(fsync), .rxd(rxd),
        .pair_en(pair_en), .rd_en(rd_en), .irq(irq), .cap_q(cap_q)
    );

    // {slot0, mask0, slot1, mask1, expected cap}; slot FF = no error, cap FF = no irq
    localparam logic [39:0] VEC [6] = '{
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF},
        {8'h00, 8'h01, 8'hFF, 8'h00, 8'h00},
        {8'h1F, 8'h80, 8'hFF, 8'h00, 8'h1F},
        {8'hFF, 8'h00, 8'h07, 8'h10, 8'h87},
        {8'h0C, 8'hFF, 8'hFF, 8'h00, 8'h0C},
        {8'hFF, 8'h00, 8'h19, 8'h01, 8'h99}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input int s0, input logic [7:0] m0, input int s1,
                             input logic [7:0] m1, input bit fs, input int rd_idx);
        logic base;
        seen = irq;
        rise_at = -1;
        for (int s = 0; s < SLOTS; s++) begin
            for (int b = 0; b < 8; b++) begin
                @(negedge clk);
                if (irq && !seen) begin seen = 1; rise_at = s*8 + b - 1; end
                base   = ((s*5 + b*3) % 7) > 2;
                rxd[0] = base;
                rxd[1] = base ^ (s == s0 && m0[b]);
                rxd[2] = ~base;
                rxd[3] = ~base ^ (s == s1 && m1[b]);
                fsync  = fs && s == 0 && b == 0;
                rd_en  = (s*8 + b) == rd_idx;
                @(posedge clk);
            end
        end
        #1;
        if (irq && !seen) begin seen = 1; rise_at = SLOTS*8 - 1; end
        fsync = 1'b0; rd_en = 1'b0; rxd = 4'h0;
    endtask

    task automatic read_clear(input string req);
        @(negedge clk); rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk); rd_en = 1'b0;
        chk({req, " irq after read"}, 32'(irq), 32'd0);
        chk({req, " cap after read"}, 32'(cap_q), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 irq at reset", 32'(irq), 32'd0);
        chk("R1 cap at reset", 32'(cap_q), 32'd0);
        rst = 1'b0;

        // Table walk: R2, R3, R4, R12, R6
        for (int i = 0; i < 6; i++) begin
            logic [39:0] v;
            v = VEC[i];
            run_frame((v[39:32] == 8'hFF) ? -1 : int'(v[39:32]), v[31:24],
                      (v[23:16] == 8'hFF) ? -1 : int'(v[23:16]), v[15:8], 1'b1, -1);
            if (v[7:0] == 8'hFF) begin
                chk("R2 equal lines no irq", 32'(irq), 32'd0);
            end else begin
                chk("R3 irq on mismatch", 32'(irq), 32'd1);
                chk("R3 R4 capture word", 32'(cap_q), 32'(v[7:0]));
                chk("R12 irq rise sample", 32'(rise_at), 32'(int'(v[6:0])*8 + 7));
                read_clear("R6");
            end
        end

        // R5: later mismatch keeps first capture
        run_frame(5, 8'h04, 20, 8'h02, 1'b1, -1);
        chk("R5 first capture held", 32'(cap_q), 32'h05);
        chk("R5 irq held", 32'(irq), 32'd1);
        // R7: read on the same edge as a new decision
        run_frame(-1, 8'h00, 9, 8'h80, 1'b1, 9*8 + 7);
        chk("R7 new mismatch wins cap", 32'(cap_q), 32'h89);
        chk("R7 irq stays", 32'(irq), 32'd1);
        read_clear("R6 after R7");

        // R10: both pairs in the same slot
        run_frame(14, 8'h08, 14, 8'h01, 1'b1, -1);
        chk("R10 pair 0 priority", 32'(cap_q), 32'h0E);
        read_clear("R6 after R10");

        // R8: pair 0 disabled
        pair_en = 2'b10;
        run_frame(3, 8'hFF, -1, 8'h00, 1'b1, -1);
        chk("R8 disabled pair silent", 32'(irq), 32'd0);
        run_frame(3, 8'hFF, 11, 8'h20, 1'b1, -1);
        chk("R8 other pair active", 32'(cap_q), 32'h8B);
        read_clear("R6 after R8");
        pair_en = 2'b11;

        // R9: sync after an odd number of idle bits realigns the count
        repeat (5) @(posedge clk);
        run_frame(4, 8'h40, -1, 8'h00, 1'b1, -1);
        chk("R9 slot relative to sync", 32'(cap_q), 32'h04);
        read_clear("R6 after R9");

        // R11: second frame without sync relies on the wrap
        run_frame(-1, 8'h00, -1, 8'h00, 1'b1, -1);
        run_frame(6, 8'h01, -1, 8'h00, 1'b0, -1);
        chk("R11 wrap slot number", 32'(cap_q), 32'h06);
        chk("R12 rise after wrap", 32'(rise_at), 32'(6*8 + 7));

        // R1: reset discards a pending capture
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 irq cleared by reset", 32'(irq), 32'd0);
        chk("R1 cap cleared by reset", 32'(cap_q), 32'd0);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule